// File: doc/BRIEF.md
# Serial Bit Stuffer and Destuffer

This block sits between a frame engine and the serial line of a CAN-style data link. Its transmit half takes one payload bit on each bit-time strobe, adds an opposite-level bit after every run of equal bits that reaches the run limit, and stalls the payload source while that extra bit is on the line. Its receive half samples one line bit per strobe, drops the extra bit that follows a full run, forwards the remaining payload bits with a one-clock valid pulse, and raises an error pulse when a run grows past the limit. The extra bits exist so that the line always carries enough edges for receivers to resynchronize their bit timing.

A single `stuff_en` input marks the part of a frame where stuffing applies. While it is low both halves pass bits straight through and hold their run trackers cleared, so the frame engine lowers it at frame start and at the CRC delimiter to begin a fresh run count. Each half is a small state machine. Transmit states: TX_IDLE (no run yet), TX_RUN (counting a run) and TX_STUFF (an extra bit is due). Transitions: TX_IDLE or TX_RUN go to TX_STUFF when the bit just sent fills the run, otherwise to TX_RUN; TX_STUFF goes to TX_RUN after the extra bit; any state goes to TX_IDLE on a strobe with `stuff_en` low. Receive states: RX_IDLE, RX_RUN and RX_EXPECT (next bit must be an extra bit). RX_IDLE or RX_RUN go to RX_EXPECT when a run fills, else to RX_RUN; RX_EXPECT goes to RX_RUN on an opposite-level bit and to RX_IDLE on an equal bit (error); any state goes to RX_IDLE on a strobe with `stuff_en` low.

Top module: `bit_stuff_codec`

## Requirements
- R1: With `stuff_en` high, after RUN_LEN (default 5) consecutive transmitted bits of one level, the next strobe drives a single bit of the opposite level on `tx_serial`.
- R2: An inserted bit starts a new run of length one that counts toward the next insertion, on both the transmit and the receive side (line 0,0,0,0,0,1,1,1,1,1 is followed by an inserted 0).
- R3: `tx_ready` is low during the bit time in which an inserted bit is due; the `tx_data` offered at that strobe is not sent and is taken at the next strobe.
- R4: `tx_serial` changes only one clock after a strobe edge and holds its value between strobes.
- R5: The receiver drops the bit that follows RUN_LEN equal bits when it has the opposite level: no `rx_valid` pulse for it, and the run continues from it.
- R6: If the bit after RUN_LEN equal received bits has the same level, `rx_stuff_err` pulses high for one clock with no `rx_valid`, and the run count restarts from zero.
- R7: A strobe with `stuff_en` low passes the bit through unchanged on both sides (no insertion, no removal, no error) and clears the run trackers.
- R8: Every accepted receive bit gives a one-clock `rx_valid` pulse one clock after its strobe, with the bit on `rx_data`.
- R9: Synchronous active-high reset gives `tx_serial` = 1, `tx_ready` = 1, `rx_valid` = 0, `rx_stuff_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One-clock strobe per bit time |
| stuff_en | input | 1 | High inside the stuffed region of a frame |
| tx_data | input | 1 | Payload bit offered to the transmitter |
| tx_ready | output | 1 | High when the next strobe takes `tx_data` |
| tx_serial | output | 1 | Serial line output |
| rx_serial | input | 1 | Serial line input, sampled on the strobe |
| rx_data | output | 1 | Destuffed payload bit |
| rx_valid | output | 1 | One-clock pulse marking `rx_data` valid |
| rx_stuff_err | output | 1 | One-clock pulse on a run longer than the limit |

## Verification
The transmitter is driven with a long run of zeros that continues into ones, which shows whether the inserted bit is counted as the start of the next run, and with an alternating pattern that must never trigger an insertion. A run broken by a low `stuff_en` strobe separates a tracker that is cleared from one that keeps counting. The receiver gets a line with two chained inserted bits, a line where a sixth equal bit arrives, and a long run while disabled, which together tell removal, error detection and pass-through apart.

// File: rtl/bit_stuff_pkg.sv
package bit_stuff_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_RUN   = 2'd1,
        TX_STUFF = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_RUN    = 2'd1,
        RX_EXPECT = 2'd2
    } rx_state_e;

endpackage

// File: rtl/run_tracker.sv
module run_tracker #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic advance,
    input  logic bit_in,
    output logic run_lvl,
    output logic will_fill
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] PRE_FULL = CNT_W'(RUN_LEN - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             lvl_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else if (advance) begin
            if (cnt_q != '0 && bit_in == lvl_q && cnt_q != FULL)
                cnt_q <= cnt_q + ONE;
            else
                cnt_q <= ONE;
            lvl_q <= bit_in;
        end
    end

    assign run_lvl   = lvl_q;
    assign will_fill = (cnt_q == PRE_FULL) && (bit_in == lvl_q);

    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL) else $error("run count past limit"); // R1

endmodule

// File: rtl/stuff_tx.sv
module stuff_tx
    import bit_stuff_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic stuff_en,
    input  logic data_in,
    output logic ready,
    output logic bit_out
);
    tx_state_e state_q, state_d;
    logic      out_q, out_d;
    logic      adv, clr, adv_bit;
    logic      run_lvl, will_fill;

    run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
        .clk       (clk),
        .rst       (rst),
        .clear     (clr),
        .advance   (adv),
        .bit_in    (adv_bit),
        .run_lvl   (run_lvl),
        .will_fill (will_fill)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= TX_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b1;
        else     out_q <= out_d;
    end

    always_comb begin
        state_d = state_q;
        out_d   = out_q;
        adv     = 1'b0;
        clr     = 1'b0;
        adv_bit = data_in;
        if (bit_stb) begin
            if (!stuff_en) begin
                state_d = TX_IDLE;
                clr     = 1'b1;
                out_d   = data_in;
            end else begin
                unique case (state_q)
                    TX_IDLE, TX_RUN: begin
                        adv     = 1'b1;
                        out_d   = data_in;
                        state_d = will_fill ? TX_STUFF : TX_RUN;
                    end
                    TX_STUFF: begin
                        adv     = 1'b1;
                        adv_bit = ~run_lvl;
                        out_d   = ~run_lvl;
                        state_d = TX_RUN;
                    end
                    default: state_d = TX_IDLE;
                endcase
            end
        end
    end

    assign ready   = !(stuff_en && state_q == TX_STUFF);
    assign bit_out = out_q;

    AST_TX_STUFF_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && stuff_en && !ready) |=> (bit_out != $past(bit_out))) else $error("stuff bit not opposite"); // R1
    AST_TX_READY_BACK: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && stuff_en && !ready) |=> ready) else $error("ready held low twice"); // R3
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |=> $stable(bit_out)) else $error("output moved off strobe"); // R4
    AST_TX_PASS_OFF: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && !stuff_en) |=> (bit_out == $past(data_in))) else $error("pass-through broken"); // R7

endmodule

// File: rtl/destuff_rx.sv
module destuff_rx
    import bit_stuff_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic stuff_en,
    input  logic bit_in,
    output logic data_out,
    output logic valid,
    output logic stuff_err
);
    rx_state_e state_q, state_d;
    logic      data_q, data_d;
    logic      valid_q, valid_d;
    logic      err_q, err_d;
    logic      adv, clr;
    logic      run_lvl, will_fill;

    run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
        .clk       (clk),
        .rst       (rst),
        .clear     (clr),
        .advance   (adv),
        .bit_in    (bit_in),
        .run_lvl   (run_lvl),
        .will_fill (will_fill)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= RX_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= 1'b1;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            data_q  <= data_d;
            valid_q <= valid_d;
            err_q   <= err_d;
        end
    end

    always_comb begin
        state_d = state_q;
        data_d  = data_q;
        valid_d = 1'b0;
        err_d   = 1'b0;
        adv     = 1'b0;
        clr     = 1'b0;
        if (bit_stb) begin
            if (!stuff_en) begin
                state_d = RX_IDLE;
                clr     = 1'b1;
                data_d  = bit_in;
                valid_d = 1'b1;
            end else begin
                unique case (state_q)
                    RX_IDLE, RX_RUN: begin
                        adv     = 1'b1;
                        data_d  = bit_in;
                        valid_d = 1'b1;
                        state_d = will_fill ? RX_EXPECT : RX_RUN;
                    end
                    RX_EXPECT: begin
                        if (bit_in != run_lvl) begin
                            adv     = 1'b1;
                            state_d = RX_RUN;
                        end else begin
                            clr     = 1'b1;
                            err_d   = 1'b1;
                            state_d = RX_IDLE;
                        end
                    end
                    default: state_d = RX_IDLE;
                endcase
            end
        end
    end

    assign data_out  = data_q;
    assign valid     = valid_q;
    assign stuff_err = err_q;

    AST_RX_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        stuff_err |-> !valid) else $error("data with error"); // R6
    AST_RX_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        stuff_err |=> !stuff_err) else $error("error wider than one clock"); // R6
    AST_RX_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (valid && !bit_stb) |=> !valid) else $error("valid wider than one clock"); // R8
    AST_RX_PASS_OFF: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && !stuff_en) |=> (valid && !stuff_err && data_out == $past(bit_in))) else $error("pass-through broken"); // R7

endmodule

// File: rtl/bit_stuff_codec.sv
module bit_stuff_codec #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic stuff_en,
    input  logic tx_data,
    output logic tx_ready,
    output logic tx_serial,
    input  logic rx_serial,
    output logic rx_data,
    output logic rx_valid,
    output logic rx_stuff_err
);
    stuff_tx #(.RUN_LEN(RUN_LEN)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .bit_stb  (bit_stb),
        .stuff_en (stuff_en),
        .data_in  (tx_data),
        .ready    (tx_ready),
        .bit_out  (tx_serial)
    );

    destuff_rx #(.RUN_LEN(RUN_LEN)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (bit_stb),
        .stuff_en  (stuff_en),
        .bit_in    (rx_serial),
        .data_out  (rx_data),
        .valid     (rx_valid),
        .stuff_err (rx_stuff_err)
    );

endmodule

// File: tb/test_bit_stuff_codec.sv
module test_bit_stuff_codec;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_stb = 1'b0;
    logic stuff_en = 1'b0;
    logic tx_data = 1'b1;
    logic rx_serial = 1'b1;
    logic tx_ready, tx_serial, rx_data, rx_valid, rx_stuff_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic rdy_seen, got_tx, got_v, got_d, got_e;

    always #2.5ns clk = ~clk;

    bit_stuff_codec #(.RUN_LEN(5)) i_bit_stuff_codec (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .stuff_en(stuff_en),
        .tx_data(tx_data), .tx_ready(tx_ready), .tx_serial(tx_serial),
        .rx_serial(rx_serial), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_stuff_err(rx_stuff_err)
    );

    task automatic chk(input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic pulse(input logic txd, input logic rxd);
        @(negedge clk);
        tx_data = txd;
        rx_serial = rxd;
        rdy_seen = tx_ready;
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        got_tx = tx_serial;
        got_v = rx_valid;
        got_d = rx_data;
        got_e = rx_stuff_err;
        repeat (2) @(negedge clk);
    endtask

    task automatic flush();
        stuff_en = 1'b0;
        pulse(1'b1, 1'b1);
        stuff_en = 1'b1;
    endtask

    task automatic t_reset();
        chk("R9 tx_serial", tx_serial, 1'b1);
        chk("R9 tx_ready", tx_ready, 1'b1);
        chk("R9 rx_valid", rx_valid, 1'b0);
        chk("R9 rx_stuff_err", rx_stuff_err, 1'b0);
    endtask

    task automatic t_tx_chain();
        flush();
        for (int i = 0; i < 5; i++) begin
            pulse(1'b0, 1'b1);
            chk("R1 run bit ready", rdy_seen, 1'b1);
            chk("R1 run bit level", got_tx, 1'b0);
        end
        pulse(1'b1, 1'b1);
        chk("R3 ready low on stuff", rdy_seen, 1'b0);
        chk("R1 stuff bit level", got_tx, 1'b1);
        chk("R4 hold between strobes", tx_serial, 1'b1);
        for (int i = 0; i < 4; i++) begin
            pulse(1'b1, 1'b1);
            chk("R3 data taken after stuff", rdy_seen, 1'b1);
            chk("R2 data after stuff", got_tx, 1'b1);
        end
        pulse(1'b1, 1'b1);
        chk("R2 chained stuff ready", rdy_seen, 1'b0);
        chk("R2 chained stuff level", got_tx, 1'b0);
    endtask

    task automatic t_tx_alternate();
        flush();
        for (int i = 0; i < 10; i++) begin
            pulse(logic'(i % 2), 1'b1);
            chk("R1 no stuff on alternating", rdy_seen, 1'b1);
            chk("R1 alternating level", got_tx, logic'(i % 2));
        end
    endtask

    task automatic t_tx_disable();
        flush();
        for (int i = 0; i < 4; i++) pulse(1'b0, 1'b1);
        stuff_en = 1'b0;
        pulse(1'b0, 1'b1);
        chk("R7 disabled passes", got_tx, 1'b0);
        stuff_en = 1'b1;
        for (int i = 0; i < 4; i++) pulse(1'b0, 1'b1);
        chk("R7 run cleared by disable", tx_ready, 1'b1);
        pulse(1'b0, 1'b1);
        chk("R7 fresh run fills", tx_ready, 1'b0);
        stuff_en = 1'b0;
        for (int i = 0; i < 7; i++) begin
            pulse(1'b0, 1'b0);
            chk("R7 no stuff while off", rdy_seen, 1'b1);
            chk("R7 off level", got_tx, 1'b0);
            chk("R7 rx off valid", got_v, 1'b1);
            chk("R7 rx off no error", got_e, 1'b0);
        end
    endtask

    task automatic t_rx_destuff();
        flush();
        for (int i = 0; i < 5; i++) begin
            pulse(1'b1, 1'b1);
            chk("R8 rx valid", got_v, 1'b1);
            chk("R8 rx data", got_d, 1'b1);
        end
        chk("R8 valid is one clock", rx_valid, 1'b0);
        pulse(1'b1, 1'b0);
        chk("R5 stuff dropped", got_v, 1'b0);
        chk("R5 no error on stuff", got_e, 1'b0);
        for (int i = 0; i < 4; i++) begin
            pulse(1'b1, 1'b0);
            chk("R5 data after stuff valid", got_v, 1'b1);
            chk("R5 data after stuff", got_d, 1'b0);
        end
        pulse(1'b1, 1'b1);
        chk("R2 rx chained stuff dropped", got_v, 1'b0);
        chk("R2 rx chained no error", got_e, 1'b0);
        pulse(1'b1, 1'b1);
        chk("R8 rx resumes", got_v, 1'b1);
        chk("R8 rx resumes data", got_d, 1'b1);
    endtask

    task automatic t_rx_error();
        flush();
        for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        chk("R6 error raised", got_e, 1'b1);
        chk("R6 no valid on error", got_v, 1'b0);
        chk("R6 error one clock", rx_stuff_err, 1'b0);
        for (int i = 0; i < 5; i++) begin
            pulse(1'b1, 1'b0);
            chk("R6 run restarts", got_v, 1'b1);
            chk("R6 no repeat error", got_e, 1'b0);
        end
        pulse(1'b1, 1'b1);
        chk("R6 stuff after restart dropped", got_v, 1'b0);
    endtask

    initial begin
        #1ms;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tx_chain();
        t_tx_alternate();
        t_tx_disable();
        t_rx_destuff();
        t_rx_error();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule